// File: doc/BRIEF.md
# Dual-Region Packet Buffer Controller

This block holds one 256-byte byte-wide memory shared by three parties: a host register port, a receive engine and a transmit engine. The receive engine stores incoming bytes starting at a programmable receive base. The transmit engine streams a programmed number of bytes out from a programmable transmit base. The host reaches the memory through a data register that works on an auto-incrementing access pointer. Both base pointers can sit anywhere in the memory, so the two regions may overlap, or either direction can use the whole buffer.

The block records the start address of the most recent received packet, its byte count (header-length mode only) and its CRC error status, all readable as host registers. The mode input selects sleep, standby, transmit or receive. On entry to sleep the memory is wiped and the data register is blocked. Every other mode change leaves the contents as they are.

Top module: `pktbuf_ctrl`

## Requirements
- R1: After reset the receive base reads 0x00, the transmit base 0x80, and the access pointer, payload length, current-receive address, received count and flags registers all read 0x00. Register selects on host_sel are: 0 data, 1 access pointer, 2 transmit base, 3 receive base, 4 current-receive address (read-only), 5 received count (read-only), 6 payload length, 7 flags (read-only, bit 0 = CRC error of the last packet).
- R2: The transmit base and receive base registers each accept any value 0x00 to 0xFF, independently, and read back what was written.
- R3: Outside sleep, host_rdata on select 0 shows the memory byte at the access pointer. Each cycle with host_we or host_re on select 0 writes (if host_we) that location and then advances the pointer by one, wrapping from 0xFF to 0x00.
- R4: Entering sleep (mode 0) clears every memory byte. While in sleep, data-register reads return 0x00, data-register writes are dropped, and the access pointer does not advance.
- R5: Changing between the non-sleep modes (1 standby, 2 transmit, 3 receive) leaves every memory byte unchanged.
- R6: rx_start loads the receive write address and the current-receive address register from the receive base. Each following rx_valid byte is stored at the write address, which then advances with 8-bit wrap.
- R7: On rx_end with rx_explicit high, the received count register takes rx_hdr_len. With rx_explicit low, the register keeps its value.
- R8: Received bytes are stored whatever the CRC result. Flags bit 0 takes rx_crc_bad at rx_end.
- R9: A received packet longer than the space below the transmit base keeps writing into the transmit region, overwriting what was there.
- R10: tx_start outside sleep with a non-zero payload length presents the bytes from the transmit base onward on tx_data with tx_valid, one byte per cycle with tx_ready high, wrapping at 0xFF. The cycle after the last accepted byte has tx_done high for one cycle and tx_valid low.
- R11: tx_start with payload length 0 raises tx_done in the following cycle without any tx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 sleep, 1 standby, 2 transmit, 3 receive |
| host_sel | input | 3 | Host register select |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (advances pointer on data register) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register contents |
| rx_start | input | 1 | Start of received packet |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | End of received packet |
| rx_explicit | input | 1 | Packet carried a length header |
| rx_hdr_len | input | 8 | Length from the header |
| rx_crc_bad | input | 1 | CRC failed for this packet |
| tx_start | input | 1 | Start transmit |
| tx_ready | input | 1 | Transmit sink accepts a byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_done | output | 1 | One-cycle pulse after the last byte |

## Verification
On every cycle the assertions check these points: pointer advance after a data access; a frozen pointer in sleep; memory cleared after sleep entry; untouched cells held; the current-receive capture; count retention for headerless packets; the transmit address step; and the single-cycle done pulse. The scenarios alone show byte values end to end. These cover pointer wrap in all three paths, overlap of a long packet into the transmit area, storage despite a bad CRC, retention across mode changes, and the zero-length transmit. A scoreboard compares each streamed byte against a bench model of the memory.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
    localparam int unsigned AW    = 8;
    localparam int unsigned DW    = 8;
    localparam int unsigned DEPTH = 1 << AW;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    typedef enum logic [2:0] {
        SEL_DATA   = 3'd0,
        SEL_PTR    = 3'd1,
        SEL_TXBASE = 3'd2,
        SEL_RXBASE = 3'd3,
        SEL_RXCUR  = 3'd4,
        SEL_RXCNT  = 3'd5,
        SEL_PLEN   = 3'd6,
        SEL_FLAGS  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'd0,
        MODE_STBY  = 2'd1,
        MODE_TX    = 2'd2,
        MODE_RX    = 2'd3
    } mode_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    localparam addr_t RX_BASE_RST = addr_t'(0);
    localparam addr_t TX_BASE_RST = addr_t'(DEPTH / 2);

    function automatic addr_t step(input addr_t a);
        return a + addr_t'(1);
    endfunction
endpackage

// File: rtl/pktbuf_mem.sv
module pktbuf_mem
    import pktbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  wr_req_t wr_host,
    input  wr_req_t wr_rx,
    input  addr_t   rd_addr_a,
    input  addr_t   rd_addr_b,
    output byte_t   rd_data_a,
    output byte_t   rd_data_b
);
    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else begin
            if (wr_host.en) cells[wr_host.addr] <= wr_host.data;
            if (wr_rx.en)   cells[wr_rx.addr]   <= wr_rx.data;
        end
    end

    assign rd_data_a = cells[rd_addr_a];
    assign rd_data_b = cells[rd_addr_b];

    // R4
    clear_wipes_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cells[0] == '0) && (cells[DEPTH-1] == '0) && (cells[DEPTH/2] == '0));

    // R5
    cell_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr && !(wr_host.en && wr_host.addr == '0) && !(wr_rx.en && wr_rx.addr == '0)
        |=> $stable(cells[0]));
endmodule

// File: rtl/pktbuf_rx.sv
module pktbuf_rx
    import pktbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    block,
    input  addr_t   rx_base,
    input  logic    rx_start,
    input  logic    rx_valid,
    input  byte_t   rx_data,
    input  logic    rx_end,
    input  logic    rx_explicit,
    input  byte_t   rx_hdr_len,
    input  logic    rx_crc_bad,
    output wr_req_t wr,
    output addr_t   cur_addr,
    output byte_t   rx_count,
    output logic    crc_err
);
    addr_t wptr;

    always_comb begin
        wr.en   = rx_valid && !block && !rx_start;
        wr.addr = wptr;
        wr.data = rx_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= RX_BASE_RST;
            cur_addr <= '0;
            rx_count <= '0;
            crc_err  <= 1'b0;
        end else if (!block) begin
            if (rx_start) begin
                wptr     <= rx_base;
                cur_addr <= rx_base;
            end else if (rx_valid) begin
                wptr <= step(wptr);
            end
            if (rx_end) begin
                crc_err <= rx_crc_bad;
                if (rx_explicit) rx_count <= rx_hdr_len;
            end
        end
    end

    // R6
    cur_capture_chk: assert property (@(posedge clk) disable iff (rst)
        rx_start && !block |=> cur_addr == $past(rx_base));

    // R7
    implicit_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_end && rx_explicit) |=> $stable(rx_count));
endmodule

// File: rtl/pktbuf_tx.sv
module pktbuf_tx
    import pktbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  block,
    input  addr_t tx_base,
    input  byte_t plen,
    input  logic  tx_start,
    input  logic  tx_ready,
    input  byte_t mem_data,
    output addr_t rd_addr,
    output logic  tx_valid,
    output byte_t tx_data,
    output logic  tx_done
);
    tx_state_e state;
    byte_t     remain;

    assign tx_valid = (state == TX_SEND);
    assign tx_data  = mem_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            rd_addr <= TX_BASE_RST;
            remain  <= '0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (tx_start && !block) begin
                        rd_addr <= tx_base;
                        remain  <= plen;
                        if (plen == '0) tx_done <= 1'b1;
                        else            state   <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (tx_ready) begin
                        rd_addr <= step(rd_addr);
                        remain  <= remain - byte_t'(1);
                        if (remain == byte_t'(1)) begin
                            state   <= TX_IDLE;
                            tx_done <= 1'b1;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R10
    tx_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready |=> rd_addr == $past(rd_addr) + addr_t'(1));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    // R11
    zero_len_done_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start && !block && !tx_valid && plen == '0 |=> tx_done && !tx_valid);
endmodule

// File: rtl/pktbuf_ctrl.sv
module pktbuf_ctrl
    import pktbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic [2:0] host_sel,
    input  logic       host_we,
    input  logic       host_re,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       rx_start,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_end,
    input  logic       rx_explicit,
    input  logic [7:0] rx_hdr_len,
    input  logic       rx_crc_bad,
    input  logic       tx_start,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_done
);
    reg_sel_e sel;
    logic     asleep, asleep_q, clr;
    logic     data_acc;
    addr_t    ptr, tx_base, rx_base, rx_cur, tx_rd_addr;
    byte_t    plen, rx_cnt, host_mem_data, tx_mem_data;
    logic     crc_err;
    wr_req_t  wr_host, wr_rx;

    assign sel      = reg_sel_e'(host_sel);
    assign asleep   = (mode_e'(mode) == MODE_SLEEP);
    assign clr      = asleep && !asleep_q;
    assign data_acc = (host_we || host_re) && sel == SEL_DATA && !asleep;

    always_comb begin
        wr_host.en   = host_we && sel == SEL_DATA && !asleep;
        wr_host.addr = ptr;
        wr_host.data = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep_q <= 1'b0;
            ptr      <= '0;
            tx_base  <= TX_BASE_RST;
            rx_base  <= RX_BASE_RST;
            plen     <= '0;
        end else begin
            asleep_q <= asleep;
            if (host_we && sel == SEL_PTR) ptr <= host_wdata;
            else if (data_acc)             ptr <= step(ptr);
            if (host_we && sel == SEL_TXBASE) tx_base <= host_wdata;
            if (host_we && sel == SEL_RXBASE) rx_base <= host_wdata;
            if (host_we && sel == SEL_PLEN)   plen    <= host_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DATA:   host_rdata = asleep ? '0 : host_mem_data;
            SEL_PTR:    host_rdata = ptr;
            SEL_TXBASE: host_rdata = tx_base;
            SEL_RXBASE: host_rdata = rx_base;
            SEL_RXCUR:  host_rdata = rx_cur;
            SEL_RXCNT:  host_rdata = rx_cnt;
            SEL_PLEN:   host_rdata = plen;
            SEL_FLAGS:  host_rdata = {7'd0, crc_err};
            default:    host_rdata = '0;
        endcase
    end

    pktbuf_mem u_mem (
        .clk(clk), .rst(rst), .clr(clr),
        .wr_host(wr_host), .wr_rx(wr_rx),
        .rd_addr_a(ptr), .rd_addr_b(tx_rd_addr),
        .rd_data_a(host_mem_data), .rd_data_b(tx_mem_data)
    );

    pktbuf_rx u_rx (
        .clk(clk), .rst(rst), .block(asleep), .rx_base(rx_base),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_explicit(rx_explicit), .rx_hdr_len(rx_hdr_len),
        .rx_crc_bad(rx_crc_bad), .wr(wr_rx), .cur_addr(rx_cur),
        .rx_count(rx_cnt), .crc_err(crc_err)
    );

    pktbuf_tx u_tx (
        .clk(clk), .rst(rst), .block(asleep), .tx_base(tx_base), .plen(plen),
        .tx_start(tx_start), .tx_ready(tx_ready), .mem_data(tx_mem_data),
        .rd_addr(tx_rd_addr), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_done(tx_done)
    );

    // R3
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        data_acc |=> ptr == $past(ptr) + addr_t'(1));

    // R4
    sleep_ptr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        asleep && !(host_we && sel == SEL_PTR) |=> $stable(ptr));
endmodule

// File: tb/tb_pktbuf_ctrl.sv
`timescale 1ns/1ps
module tb_pktbuf_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd1;
    logic [2:0] host_sel = 3'd0;
    logic       host_we = 1'b0, host_re = 1'b0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
    logic [7:0] rx_data = 8'd0, rx_hdr_len = 8'd0;
    logic       rx_explicit = 1'b0, rx_crc_bad = 1'b0;
    logic       tx_start = 1'b0, tx_ready = 1'b0;
    logic       tx_valid, tx_done;
    logic [7:0] tx_data;

    always #4 clk = ~clk;

    pktbuf_ctrl dut (.*);

    int errors = 0, checks = 0;
    logic [7:0] model [256];
    logic [7:0] exp_q [$];
    logic       done_due = 1'b0;
    logic       in_sleep = 1'b0;
    logic [7:0] bptr = 8'd0;
    string      tx_tag = "R10";
    int unsigned rcnt = 0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_we = 1'b1; host_wdata = d;
        if (s == 3'd1) bptr = d;
        if (s == 3'd0 && !in_sleep) begin model[bptr] = d; bptr = bptr + 8'd1; end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic regread(input logic [2:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_sel = s;
        #1 check(tag, host_rdata, exp);
    endtask

    task automatic hread(input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_sel = 3'd0; host_re = 1'b1;
        #1 check(tag, host_rdata, exp);
        bptr = bptr + 8'd1;
        @(negedge clk);
        host_re = 1'b0;
    endtask

    task automatic rx_packet(input logic [7:0] base, input int n, input logic [7:0] seed,
                             input logic expl, input logic [7:0] hlen, input logic bad);
        hwrite(3'd3, base);
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_data = seed + 8'(i * 7);
            model[8'(base + 8'(i))] = rx_data;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_end = 1'b1; rx_explicit = expl; rx_hdr_len = hlen; rx_crc_bad = bad;
        @(negedge clk);
        rx_end = 1'b0;
    endtask

    task automatic tx_run(input logic [7:0] base, input logic [7:0] len, input string tag);
        hwrite(3'd2, base);
        hwrite(3'd6, len);
        tx_tag = tag;
        for (int i = 0; i < len; i++) exp_q.push_back(model[8'(base + 8'(i))]);
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        if (len == 8'd0) done_due = 1'b1;
        while (exp_q.size() != 0 || done_due) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // ready pattern
    always @(negedge clk) begin
        rcnt++;
        tx_ready = (rcnt % 3) != 1;
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (done_due) begin
                    check({tx_tag, " done"}, {7'd0, tx_done}, 8'd1);
                    check({tx_tag, " valid after done"}, {7'd0, tx_valid}, 8'd0);
                    done_due = 1'b0;
                end else if (tx_done) begin
                    check({tx_tag, " unexpected done"}, 8'd1, 8'd0);
                end
                if (tx_valid && tx_ready) begin
                    if (exp_q.size() == 0) begin
                        check({tx_tag, " extra byte"}, tx_data, 8'hXX);
                    end else begin
                        check({tx_tag, " byte"}, tx_data, exp_q.pop_front());
                        if (exp_q.size() == 0) done_due = 1'b1;
                    end
                end
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        regread(3'd3, 8'h00, "R1 rxbase");
        regread(3'd2, 8'h80, "R1 txbase");
        regread(3'd1, 8'h00, "R1 ptr");
        regread(3'd5, 8'h00, "R1 rxcnt");
        regread(3'd4, 8'h00, "R1 rxcur");
        regread(3'd6, 8'h00, "R1 plen");
        regread(3'd7, 8'h00, "R1 flags");

        // R2 independent bases
        hwrite(3'd2, 8'h33);
        hwrite(3'd3, 8'hF0);
        regread(3'd2, 8'h33, "R2 txbase");
        regread(3'd3, 8'hF0, "R2 rxbase");
        hwrite(3'd2, 8'h00);
        regread(3'd3, 8'hF0, "R2 rxbase untouched");
        regread(3'd2, 8'h00, "R2 txbase zero");

        // R3 write with wrap, read back
        hwrite(3'd1, 8'hFE);
        hwrite(3'd0, 8'hA1);
        hwrite(3'd0, 8'hA2);
        hwrite(3'd0, 8'hA3);
        regread(3'd1, 8'h01, "R3 ptr wrap");
        hwrite(3'd1, 8'hFE);
        hread(8'hA1, "R3 read FE");
        hread(8'hA2, "R3 read FF");
        hread(8'hA3, "R3 read 00");
        regread(3'd1, 8'h01, "R3 ptr after reads");

        // R5 retention across non-sleep modes
        @(negedge clk) mode = 2'd2;
        @(negedge clk) mode = 2'd3;
        @(negedge clk) mode = 2'd1;
        hwrite(3'd1, 8'hFF);
        hread(8'hA2, "R5 retained FF");

        // R9 preload transmit area, then R6 R7 R8 long packet with bad CRC
        hwrite(3'd2, 8'h14);
        hwrite(3'd1, 8'h14);
        hwrite(3'd0, 8'hEE);
        hwrite(3'd0, 8'hEF);
        rx_packet(8'h10, 6, 8'h40, 1'b1, 8'd6, 1'b1);
        regread(3'd4, 8'h10, "R6 rxcur");
        regread(3'd5, 8'h06, "R7 explicit count");
        regread(3'd7, 8'h01, "R8 crc flag set");
        hwrite(3'd1, 8'h10);
        for (int i = 0; i < 6; i++)
            hread(8'h40 + 8'(i * 7), (i >= 4) ? "R9 overwrite tx area" : "R8 stored bad crc");

        // R6 wrap, R7 implicit keeps count, R8 flag clears
        rx_packet(8'hFE, 3, 8'h90, 1'b0, 8'd99, 1'b0);
        regread(3'd4, 8'hFE, "R6 rxcur wrap");
        regread(3'd5, 8'h06, "R7 implicit hold");
        regread(3'd7, 8'h00, "R8 crc flag clear");
        hwrite(3'd1, 8'hFE);
        hread(8'h90, "R6 byte FE");
        hread(8'h97, "R6 byte FF");
        hread(8'h9E, "R6 byte 00");

        // R10 transmit streams, R11 zero length
        tx_run(8'h10, 8'd6, "R10 linear");
        tx_run(8'hFE, 8'd3, "R10 wrap");
        tx_run(8'h20, 8'd0, "R11 zero length");

        // R4 sleep clear and blocking
        hwrite(3'd1, 8'h20);
        hwrite(3'd0, 8'h77);
        hwrite(3'd1, 8'h20);
        @(negedge clk) mode = 2'd0; in_sleep = 1'b1;
        repeat (2) @(negedge clk);
        regread(3'd0, 8'h00, "R4 sleep read zero");
        hwrite(3'd0, 8'h55);
        @(negedge clk) host_sel = 3'd0; host_re = 1'b1;
        @(negedge clk) host_re = 1'b0;
        regread(3'd1, 8'h20, "R4 ptr frozen");
        @(negedge clk) mode = 2'd1; in_sleep = 1'b0;
        for (int i = 0; i < 256; i++) model[i] = 8'd0;
        hread(8'h00, "R4 cleared 20");
        hwrite(3'd1, 8'h10);
        hread(8'h00, "R4 cleared 10");
        hwrite(3'd1, 8'hFE);
        hread(8'h00, "R4 cleared FE");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule